// File: doc/BRIEF.md
# Packed Signed Widening Unit

This unit takes packed signed integers from the least significant part of a 128-bit source vector and widens each one, with sign extension, into a packed destination vector of wider elements. A 3-bit operation selector picks one of six width pairings (8 to 16, 8 to 32, 8 to 64, 16 to 32, 16 to 64 and 32 to 64 bits). Source element i lands in destination element i, with element 0 at bit 0. In a 128-bit form the number of elements moved is 128 divided by the destination element width.

A 2-bit encoding class decides what happens to destination bits 255:128. The legacy 128-bit class passes the current upper half through unchanged. The new-style 128-bit class clears it. The 256-bit class fills it with a second lane, fed from the source bits just above those the low lane used. For the new-style classes, a 4-bit spare-register field and a vector-length bit are checked against the encoding rules. A rule violation, a reserved selector or a reserved class raises an undefined-instruction flag, drops write-enable and returns the current destination unchanged. Results appear one clock after an input valid, together with an output valid pulse.

Top module: `sx_widen_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_we` and `out_undef` on the next clock edge.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. The result, write-enable and undefined flag shown with it come from the inputs of that accepted cycle.
- R3: For selector values 0 to 5 (8→16, 8→32, 8→64, 16→32, 16→64, 32→64 bits), the low 128 result bits hold 128/dst_width elements. Element i is the sign-extended source field i, and fields are packed from source bit 0 upward.
- R4: With encoding class 0 (legacy 128-bit), result bits 255:128 equal the `dst_cur` upper half presented with the input.
- R5: With encoding class 1 (new-style 128-bit) and no undefined condition, result bits 255:128 are zero.
- R6: With encoding class 2 (256-bit), result bits 255:128 are built as in R3 from the source bits starting at bit 128×src_width/dst_width. For 8→16 these are bits 127:64, and for 8→64 they are bits 31:16.
- R7: With class 1 or 2, `out_undef` is raised when `xreg` is not 4'b1111. Class 0 ignores `xreg` and `vlen`.
- R8: With class 1, `out_undef` is also raised when `vlen` is 1.
- R9: Selector values 6 and 7, and encoding class 3, always raise `out_undef`.
- R10: Whenever `out_undef` is high, `out_we` is low and `out_result` equals the `dst_cur` presented with the input. Otherwise `out_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| opc_lo | input | 3 | Width-pairing selector |
| enc_class | input | 2 | 0 legacy 128, 1 new 128, 2 new 256, 3 reserved |
| vlen | input | 1 | Vector-length bit |
| xreg | input | 4 | Spare register field, must be all ones for new-style classes |
| src | input | 128 | Source vector |
| dst_cur | input | 256 | Current destination value |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 256 | New destination value |
| out_we | output | 1 | Destination write-enable |
| out_undef | output | 1 | Undefined-instruction flag |

## Verification
The hardest case to reach is the high lane of the 256-bit class. Its source window begins at a different bit for each selector, so a wrong offset goes unnoticed unless the fields right at that boundary differ in sign from their neighbours. Directed vectors put 0x80 and 0x7F byte patterns that change across every candidate window edge. Random stimulus then spans all selectors, all classes and rarely legal rule fields, so each undefined cause shows up both alone and in combination with the others.

// File: rtl/sx_widen_pkg.sv
package sx_widen_pkg;
   localparam int unsigned OPC_W   = 3;
   localparam int unsigned ENC_W   = 2;
   localparam int unsigned N_MODES = 6;

   typedef enum logic [ENC_W-1:0] {
      ENC_LEG128 = 2'd0,
      ENC_NEW128 = 2'd1,
      ENC_NEW256 = 2'd2,
      ENC_RSVD   = 2'd3
   } enc_class_e;

   // source element width for a selector value
   function automatic int unsigned sx_src_w(input int unsigned m);
      if (m >= 5) return 32;
      else if (m >= 3) return 16;
      else return 8;
   endfunction

   // destination element width for a selector value
   function automatic int unsigned sx_dst_w(input int unsigned m);
      case (m)
         0: return 16;
         1: return 32;
         3: return 32;
         default: return 64;
      endcase
   endfunction
endpackage

// File: rtl/sx_lane_extend.sv
module sx_lane_extend
   import sx_widen_pkg::*;
#(
   parameter int unsigned LANE_W = 128
) (
   input  logic [OPC_W-1:0]    mode,
   input  logic [LANE_W/2-1:0] seg,
   output logic [LANE_W-1:0]   wide
);
   localparam int unsigned HALF_W = LANE_W / 2;

   logic [N_MODES-1:0][LANE_W-1:0] cand;

   // one candidate per width pairing, each element sign-extended
   for (genvar m = 0; m < N_MODES; m++) begin : g_mode
      localparam int unsigned SW = sx_src_w(m);
      localparam int unsigned DW = sx_dst_w(m);
      localparam int unsigned NE = LANE_W / DW;
      for (genvar e = 0; e < NE; e++) begin : g_elem
         assign cand[m][e*DW +: DW] = {{(DW-SW){seg[e*SW+SW-1]}}, seg[e*SW +: SW]};
      end
   end

   always_comb begin
      wide = '0;
      for (int m = 0; m < N_MODES; m++)
         if (mode == OPC_W'(m)) wide = cand[m];
   end

   if (HALF_W * 2 != LANE_W) begin : g_bad_lane
      $error("sx_lane_extend: LANE_W must be even");
   end
endmodule

// File: rtl/sx_rule_check.sv
module sx_rule_check
   import sx_widen_pkg::*;
#(
   parameter int unsigned XREG_W = 4
) (
   input  logic [OPC_W-1:0]  opc_lo,
   input  logic [ENC_W-1:0]  enc_class,
   input  logic              vlen,
   input  logic [XREG_W-1:0] xreg,
   output logic              undef
);
   localparam logic [XREG_W-1:0] XREG_OK = '1;

   logic bad_opc, bad_enc;

   always_comb begin
      bad_opc = (opc_lo >= OPC_W'(N_MODES));
      case (enc_class_e'(enc_class))
         ENC_LEG128: bad_enc = 1'b0;
         ENC_NEW128: bad_enc = (xreg != XREG_OK) || vlen;
         ENC_NEW256: bad_enc = (xreg != XREG_OK);
         default:    bad_enc = 1'b1;
      endcase
      undef = bad_opc || bad_enc;
   end
endmodule

// File: rtl/sx_widen_unit.sv
module sx_widen_unit
   import sx_widen_pkg::*;
#(
   parameter int unsigned LANE_W = 128,
   parameter int unsigned XREG_W = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [2:0]          opc_lo,
   input  logic [1:0]          enc_class,
   input  logic                vlen,
   input  logic [XREG_W-1:0]   xreg,
   input  logic [LANE_W-1:0]   src,
   input  logic [2*LANE_W-1:0] dst_cur,
   output logic                out_valid,
   output logic [2*LANE_W-1:0] out_result,
   output logic                out_we,
   output logic                out_undef
);
   localparam int unsigned DST_W  = 2 * LANE_W;
   localparam int unsigned HALF_W = LANE_W / 2;

   if (LANE_W < 64 || (LANE_W % 64) != 0) begin : g_bad_lane
      $error("sx_widen_unit: LANE_W must be a multiple of 64");
   end
   if (XREG_W < 1) begin : g_bad_xreg
      $error("sx_widen_unit: XREG_W must be at least 1");
   end
   if (OPC_W != 3) begin : g_bad_opc
      $error("sx_widen_unit: selector port assumes OPC_W of 3");
   end

   logic [HALF_W-1:0]               seg_lo, seg_hi;
   logic [N_MODES-1:0][HALF_W-1:0]  hi_cand;
   logic [LANE_W-1:0]               wide_lo, wide_hi, upper_next;
   logic [DST_W-1:0]                res_next;
   logic                            undef_c;

   assign seg_lo = src[HALF_W-1:0];

   // high-lane window starts where the low lane stopped consuming source
   for (genvar m = 0; m < N_MODES; m++) begin : g_hi_win
      localparam int unsigned SKIP = LANE_W * sx_src_w(m) / sx_dst_w(m);
      assign hi_cand[m] = src[SKIP +: HALF_W];
   end

   always_comb begin
      seg_hi = '0;
      for (int m = 0; m < N_MODES; m++)
         if (opc_lo == OPC_W'(m)) seg_hi = hi_cand[m];
   end

   sx_lane_extend #(.LANE_W(LANE_W)) u_lane_lo (
      .mode(opc_lo), .seg(seg_lo), .wide(wide_lo)
   );

   sx_lane_extend #(.LANE_W(LANE_W)) u_lane_hi (
      .mode(opc_lo), .seg(seg_hi), .wide(wide_hi)
   );

   sx_rule_check #(.XREG_W(XREG_W)) u_rules (
      .opc_lo(opc_lo), .enc_class(enc_class), .vlen(vlen),
      .xreg(xreg), .undef(undef_c)
   );

   always_comb begin
      case (enc_class_e'(enc_class))
         ENC_NEW128: upper_next = '0;
         ENC_NEW256: upper_next = wide_hi;
         default:    upper_next = dst_cur[DST_W-1:LANE_W];
      endcase
      res_next = undef_c ? dst_cur : {upper_next, wide_lo};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_we     <= 1'b0;
         out_undef  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= res_next;
            out_we     <= !undef_c;
            out_undef  <= undef_c;
         end
      end
   end

   // R1: reset clears the output valid
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid && !out_we && !out_undef);

   // R2: one valid out for each valid in, one cycle later
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
   p_valid_quiet_r2:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

   // R4: legacy class passes the upper half through
   p_legacy_upper_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && enc_class == 2'd0) |=> out_result[DST_W-1:LANE_W] == $past(dst_cur[DST_W-1:LANE_W]));

   // R5: new 128 class clears the upper half when defined
   p_new128_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && enc_class == 2'd1 && !vlen && xreg == '1 && opc_lo < 3'd6)
      |=> out_result[DST_W-1:LANE_W] == '0);

   // R8: vector-length bit set under new 128 class is undefined
   p_vlen_undef_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && enc_class == 2'd1 && vlen) |=> out_undef);

   // R9: reserved selectors and class raise the flag
   p_rsvd_undef_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (opc_lo > 3'd5 || enc_class == 2'd3)) |=> out_undef);

   // R10: flag and write-enable are exclusive, undefined keeps destination
   p_we_excl_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_we != out_undef));
   p_undef_keep_r10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opc_lo > 3'd5) |=> out_result == $past(dst_cur) && !out_we);
endmodule

// File: tb/sx_widen_unit_bench.sv
`timescale 1ns/1ps
module sx_widen_unit_bench;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [2:0]   opc_lo;
   logic [1:0]   enc_class;
   logic         vlen;
   logic [3:0]   xreg;
   logic [127:0] src;
   logic [255:0] dst_cur;
   logic         out_valid;
   logic [255:0] out_result;
   logic         out_we;
   logic         out_undef;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sx_widen_unit u_sx_widen_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opc_lo(opc_lo),
      .enc_class(enc_class), .vlen(vlen), .xreg(xreg), .src(src),
      .dst_cur(dst_cur), .out_valid(out_valid), .out_result(out_result),
      .out_we(out_we), .out_undef(out_undef)
   );

   function automatic bit exp_undef(input logic [2:0] o, input logic [1:0] c,
                                    input logic v, input logic [3:0] x);
      if (o > 3'd5 || c == 2'd3) return 1'b1;
      if (c == 2'd1 && (v || x != 4'hF)) return 1'b1;
      if (c == 2'd2 && x != 4'hF) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [255:0] exp_result(input logic [2:0] o, input logic [1:0] c,
                                               input logic v, input logic [3:0] x,
                                               input logic [127:0] s, input logic [255:0] d);
      int sw, dw, ne, lanes;
      logic [255:0] r;
      logic [127:0] t;
      if (exp_undef(o, c, v, x)) return d;
      case (o)
         3'd0: begin sw = 8;  dw = 16; end
         3'd1: begin sw = 8;  dw = 32; end
         3'd2: begin sw = 8;  dw = 64; end
         3'd3: begin sw = 16; dw = 32; end
         3'd4: begin sw = 16; dw = 64; end
         default: begin sw = 32; dw = 64; end
      endcase
      ne = 128 / dw;
      lanes = (c == 2'd2) ? 2 : 1;
      r = '0;
      if (c == 2'd0) r[255:128] = d[255:128];
      for (int l = 0; l < lanes; l++)
         for (int e = 0; e < ne; e++) begin
            t = s >> ((l*ne + e) * sw);
            for (int b = 0; b < dw; b++)
               r[l*128 + e*dw + b] = (b < sw) ? t[b] : t[sw-1];
         end
      return r;
   endfunction

   task automatic check1(input string tag, input logic [255:0] act, input logic [255:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // drive one operation at a falling edge; check its result at the next falling edge
   task automatic run_op(input logic [2:0] o, input logic [1:0] c, input logic v,
                         input logic [3:0] x, input logic [127:0] s, input logic [255:0] d);
      logic [255:0] er;
      bit eu;
      string tg, tu;
      opc_lo = o; enc_class = c; vlen = v; xreg = x; src = s; dst_cur = d;
      in_valid = 1'b1;
      er = exp_result(o, c, v, x, s, d);
      eu = exp_undef(o, c, v, x);
      @(negedge clk);
      in_valid = 1'b0;
      if (eu) tg = "R10";
      else if (c == 2'd0) tg = "R4";
      else if (c == 2'd1) tg = "R5";
      else tg = "R6";
      if (o > 3'd5 || c == 2'd3) tu = "R9";
      else if (c == 2'd1 && v) tu = "R8";
      else tu = "R7";
      check1("R2 valid", {255'd0, out_valid}, 256'd1);
      check1({tu, " undef"}, {255'd0, out_undef}, {255'd0, eu});
      check1("R10 we", {255'd0, out_we}, {255'd0, !eu});
      check1({"R3 low ", tg}, {128'd0, out_result[127:0]}, {128'd0, er[127:0]});
      check1(tg, out_result, er);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #400000;
      if (!done) begin
         n_cmp++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] edge_src;
      logic [255:0] old_dst;
      void'($urandom(32'd20240611));
      rst = 1'b1; in_valid = 1'b0; opc_lo = '0; enc_class = '0; vlen = 1'b0;
      xreg = 4'hF; src = '0; dst_cur = '0;
      repeat (3) @(negedge clk);
      check1("R1 reset valid", {255'd0, out_valid}, 256'd0);
      check1("R1 reset we", {255'd0, out_we}, 256'd0);
      rst = 1'b0;
      @(negedge clk);
      check1("R2 idle", {255'd0, out_valid}, 256'd0);

      // sign boundaries across every window edge
      edge_src = 128'h7F80_7F80_8000_7FFF_80FF_017F_8081_FE7F;
      old_dst  = {128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA, 128'h1111_2222_3333_4444_5555_6666_7777_8888};
      for (int o = 0; o < 6; o++) begin
         run_op(3'(o), 2'd0, 1'b1, 4'h0, edge_src, old_dst);   // R7: legacy ignores xreg and vlen
         run_op(3'(o), 2'd1, 1'b0, 4'hF, edge_src, old_dst);   // R5
         run_op(3'(o), 2'd2, 1'b1, 4'hF, edge_src, old_dst);   // R6
         run_op(3'(o), 2'd2, 1'b1, 4'hF, ~edge_src, old_dst);  // R6 inverted signs
      end
      run_op(3'd0, 2'd2, 1'b1, 4'hF, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF, old_dst);
      run_op(3'd2, 2'd2, 1'b1, 4'hF, 128'h0000_0000_0000_0000_0000_0000_7F80_807F, old_dst);
      run_op(3'd3, 2'd1, 1'b0, 4'hE, edge_src, old_dst);  // R7
      run_op(3'd5, 2'd2, 1'b1, 4'h7, edge_src, old_dst);  // R7
      run_op(3'd1, 2'd1, 1'b1, 4'hF, edge_src, old_dst);  // R8
      run_op(3'd6, 2'd0, 1'b0, 4'hF, edge_src, old_dst);  // R9
      run_op(3'd7, 2'd2, 1'b1, 4'hF, edge_src, old_dst);  // R9
      run_op(3'd0, 2'd3, 1'b0, 4'hF, edge_src, old_dst);  // R9 reserved class
      @(negedge clk);
      check1("R2 gap", {255'd0, out_valid}, 256'd0);

      for (int i = 0; i < 600; i++) begin
         logic [2:0] o;
         logic [1:0] c;
         logic [3:0] x;
         logic v;
         o = ($urandom % 10 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
         c = ($urandom % 12 == 0) ? 2'd3 : 2'($urandom % 3);
         x = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
         v = (c == 2'd2) ? 1'b1 : (($urandom % 6 == 0) ? 1'b1 : 1'b0);
         run_op(o, c, v, x, rnd128(), {rnd128(), rnd128()});
         if ($urandom % 8 == 0) begin
            @(negedge clk);
            check1("R2 random gap", {255'd0, out_valid}, 256'd0);
         end
      end

      rst = 1'b1;
      @(negedge clk);
      check1("R1 late reset", {255'd0, out_valid}, 256'd0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule